// File: doc/BRIEF.md
# Line-Locked Acquisition Mode Controller

This block is the digital control engine of a pixel-clock generator that locks to a horizontal sync input. It runs on a high-rate clock that stands in for the oscillator output. At every reference edge it measures how many clock cycles the last reference interval held and compares that count with a programmed divide value N. From the result it steers an oscillator control word through four acquisition modes: coarse frequency, fine frequency, coarse phase and fine phase. A fifth mode holds the word frozen while the reference is absent.

The block also contains the programmable divider that produces the divided pulse. In coarse-phase mode it can snap the divider phase onto the reference edge. The reference is first passed through a two-flop synchronizer and a rising-edge detector. A decision made on an edge therefore shows at the outputs three clock edges after the reference input rises.

Top module: `linelock_acq_ctrl`

## Requirements
- R1: The mode output uses the codes 0 = coarse frequency, 1 = fine frequency, 2 = coarse phase, 3 = fine phase and 4 = hold. After reset the mode is 0, the control word is CW_INIT (512 by default) and the lock flag is 0.
- R2: The interval P is the number of clock cycles between two successive synchronized reference rising edges. The first edge after reset only arms the measurement and changes neither mode nor word.
- R3: In coarse-frequency mode, an edge with |P−N|×25 > N moves the word by CSTEP (20): up when P < N and down when P > N. An edge with |P−N|×25 ≤ N moves to fine-frequency mode and leaves the word unchanged.
- R4: In fine-frequency mode, an edge with |P−N|×25 > N returns to coarse-frequency mode. An edge with |P−N|×50 ≤ N moves to coarse-phase mode. In both cases the word is unchanged. Otherwise the word moves by 1 toward the target.
- R5: In coarse-phase mode, the first qualifying edge restarts the divider so that the divided pulse appears in the clock cycle right after the decision, and the mode stays coarse phase. A later edge that lands within 2 clock cycles of the divider's alignment point moves to fine-phase mode.
- R6: In fine-phase mode the lock flag is 1. An edge within the phase window moves the word by 1 toward the target when P ≠ N. A phase error above 2 cycles returns to coarse-phase mode with the lock flag 0. Leaving the 2 % window returns to fine-frequency mode, and leaving the 4 % window returns to coarse-frequency mode; the same two fall-backs apply in coarse-phase mode.
- R7: When no reference edge arrives for 2×N cycles, the mode becomes hold, the word stays fixed and the lock flag is 0. The next edge restores the mode that was active before hold, with no word change.
- R8: The divided pulse is high for one cycle every N clock cycles, and follows a change of N.
- R9: The control word saturates at 0 and at 2^CW_W−1 (1023 by default) and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-rate clock standing in for the oscillator output |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Horizontal sync reference, asynchronous |
| div_n | input | NSET_W | Programmed divide value N (750 to 2600) |
| ctrl_word | output | CW_W | Oscillator control word |
| div_pulse | output | 1 | Divided pulse, one cycle per N clocks |
| mode | output | 3 | Current acquisition mode code |
| locked | output | 1 | High in fine-phase mode |

## Verification
The following rules are checked by assertions on every clock edge:
- the word never moves by more than the coarse step, and by no more than one code outside coarse-frequency mode;
- the word is frozen in hold, and hold is entered only after the loss timer reaches 2×N;
- fine phase is entered only from coarse phase or on leaving hold;
- a realignment is followed at once by a divided pulse.

Some behaviour can only be shown by the bench's scenarios:
- the exact percentage boundaries, such as an interval of 1040 against N = 1000 counting as inside 4 % while 1041 does not;
- the once-only realignment followed by phase capture;
- the return to the held mode;
- saturation at both ends of the word range;
- the divider period after N changes.

// File: rtl/linelock_acq_ctrl.sv
module linelock_acq_ctrl #(
  parameter int NSET_W  = 12,
  parameter int CW_W    = 10,
  parameter int CW_INIT = 512,
  parameter int CSTEP   = 20,
  parameter int PH_WIN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_in,
  input  logic [NSET_W-1:0] div_n,
  output logic [CW_W-1:0]   ctrl_word,
  output logic              div_pulse,
  output logic [2:0]        mode,
  output logic              locked
);
  localparam int CNT_W = NSET_W + 1;
  localparam int MW    = CNT_W + 7;
  localparam logic [CW_W-1:0] CW_MAX_V = {CW_W{1'b1}};
  localparam logic [CW_W-1:0] CSTEP_V  = CW_W'(CSTEP);
  localparam logic [CW_W-1:0] ONE_V    = CW_W'(1);

  typedef enum logic [2:0] {
    M_FRQ_C = 3'd0, M_FRQ_F = 3'd1, M_PHS_C = 3'd2, M_PHS_F = 3'd3, M_HOLD = 3'd4
  } mode_t;

  logic [2:0]        ref_sh;
  logic [CNT_W-1:0]  cnt_q, lim;
  logic [NSET_W-1:0] div_cnt;
  logic [CW_W-1:0]   word_q, word_d;
  mode_t             mode_q, mode_d, held_q, held_d;
  logic              armed_q, armed_d, rl_q, rl_d, realign;
  logic              ref_edge, lost, near, in4, in2, slow;
  logic [MW-1:0]     per_w, nx_w, diff_w;

  function automatic logic [CW_W-1:0] step_up(input logic [CW_W-1:0] w, input logic [CW_W-1:0] s);
    return (w > CW_MAX_V - s) ? CW_MAX_V : w + s;
  endfunction

  function automatic logic [CW_W-1:0] step_dn(input logic [CW_W-1:0] w, input logic [CW_W-1:0] s);
    return (w < s) ? '0 : w - s;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) ref_sh <= '0;
    else        ref_sh <= {ref_sh[1:0], ref_in};
  end
  assign ref_edge = ref_sh[1] & ~ref_sh[2];

  assign lim  = {div_n, 1'b0};
  assign lost = (cnt_q >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (ref_edge) cnt_q <= '0;
    else if (!lost)    cnt_q <= cnt_q + 1'b1;
  end

  assign per_w  = MW'(cnt_q) + MW'(1);
  assign nx_w   = MW'(div_n);
  assign diff_w = (per_w >= nx_w) ? per_w - nx_w : nx_w - per_w;
  assign in4    = (diff_w * MW'(25)) <= nx_w;
  assign in2    = (diff_w * MW'(50)) <= nx_w;
  assign slow   = (per_w < nx_w);

  assign near = ({1'b0, div_cnt} + CNT_W'(PH_WIN + 1) >= {1'b0, div_n}) ||
                (div_cnt < NSET_W'(PH_WIN));

  always_ff @(posedge clk) begin
    if (!rst_n)                                   div_cnt <= '0;
    else if (realign)                             div_cnt <= '0;
    else if ({1'b0, div_cnt} + 1'b1 >= {1'b0, div_n}) div_cnt <= '0;
    else                                          div_cnt <= div_cnt + 1'b1;
  end
  assign div_pulse = (div_cnt == '0);

  always_comb begin
    mode_d  = mode_q;
    word_d  = word_q;
    held_d  = held_q;
    armed_d = armed_q;
    rl_d    = rl_q;
    realign = 1'b0;
    if (mode_q == M_HOLD) begin
      if (ref_edge) begin
        mode_d  = held_q;
        armed_d = 1'b1;
      end
    end else if (lost && !ref_edge) begin
      held_d = mode_q;
      mode_d = M_HOLD;
    end else if (ref_edge) begin
      armed_d = 1'b1;
      if (armed_q) begin
        case (mode_q)
          M_FRQ_C: begin
            if (!in4) word_d = slow ? step_up(word_q, CSTEP_V) : step_dn(word_q, CSTEP_V);
            else      mode_d = M_FRQ_F;
          end
          M_FRQ_F: begin
            if (!in4) mode_d = M_FRQ_C;
            else if (in2) begin
              mode_d = M_PHS_C;
              rl_d   = 1'b0;
            end else word_d = slow ? step_up(word_q, ONE_V) : step_dn(word_q, ONE_V);
          end
          M_PHS_C: begin
            if (!in4)             mode_d = M_FRQ_C;
            else if (!in2)        mode_d = M_FRQ_F;
            else if (rl_q && near) mode_d = M_PHS_F;
            else begin
              realign = 1'b1;
              rl_d    = 1'b1;
            end
          end
          M_PHS_F: begin
            if (!in4)       mode_d = M_FRQ_C;
            else if (!in2)  mode_d = M_FRQ_F;
            else if (!near) begin
              mode_d = M_PHS_C;
              rl_d   = 1'b0;
            end else if (per_w != nx_w)
              word_d = slow ? step_up(word_q, ONE_V) : step_dn(word_q, ONE_V);
          end
          default: mode_d = M_FRQ_C;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= M_FRQ_C;
      held_q  <= M_FRQ_C;
      word_q  <= CW_W'(CW_INIT);
      armed_q <= 1'b0;
      rl_q    <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      held_q  <= held_d;
      word_q  <= word_d;
      armed_q <= armed_d;
      rl_q    <= rl_d;
    end
  end

  assign ctrl_word = word_q;
  assign mode      = mode_q;
  assign locked    = (mode_q == M_PHS_F);

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q <= M_HOLD); // R1
  AST_COARSE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_FRQ_C) |=> (((word_q >= $past(word_q)) ? (word_q - $past(word_q))
                                                        : ($past(word_q) - word_q)) <= CSTEP_V)); // R9
  AST_FINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != M_FRQ_C) |=> (((word_q >= $past(word_q)) ? (word_q - $past(word_q))
                                                        : ($past(word_q) - word_q)) <= ONE_V)); // R4
  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_HOLD) |=> $stable(word_q)); // R7
  AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_HOLD && $past(mode_q) != M_HOLD) |-> ($past(cnt_q) >= {$past(div_n), 1'b0})); // R7
  AST_LOCK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_PHS_F && $past(mode_q) != M_PHS_F) |->
      ($past(mode_q) == M_PHS_C || $past(mode_q) == M_HOLD)); // R5
  AST_REALIGN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> div_pulse); // R8
endmodule

// File: tb/tb_linelock_acq_ctrl.sv
module tb_linelock_acq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NROW = 19;
  localparam int GAP  [NROW] = '{1041, 1040, 1200, 900, 900, 1021, 1021, 1020, 1000, 1000,
                                 1001, 1003, 1000, 1000, 1000, 3000, 1000, 1030, 1000};
  localparam int EXP_M[NROW] = '{0, 0, 1, 0, 0, 0, 1, 1, 2, 2,
                                 3, 3, 2, 2, 3, 4, 3, 3, 1};
  localparam int EXP_W[NROW] = '{512, 492, 492, 492, 512, 532, 532, 531, 531, 531,
                                 531, 530, 530, 530, 530, 530, 530, 530, 530};
  localparam string TAG[NROW] = '{"R2", "R3", "R3", "R4", "R3", "R3", "R3", "R4", "R4", "R5",
                                  "R5", "R6", "R6", "R5", "R5", "R7", "R7", "R6", "R6"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_in = 1'b0;
  logic [11:0] div_n = 12'd1000;
  logic [9:0]  ctrl_word;
  logic        div_pulse;
  logic [2:0]  mode;
  logic        locked;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  linelock_acq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .div_n(div_n),
    .ctrl_word(ctrl_word), .div_pulse(div_pulse), .mode(mode), .locked(locked)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic edge_then(input int gap);
    @(negedge clk) ref_in = 1'b1;
    @(negedge clk) ref_in = 1'b0;
    repeat (gap - 2) @(negedge clk);
  endtask

  task automatic state_chk(input string req, input int m, input int w);
    chk(req, "mode", int'(mode), m);
    chk(req, "word", int'(ctrl_word), w);
    chk(req, "lock", int'(locked), (m == 3) ? 1 : 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ref_in = 1'b0;
    repeat (4) @(negedge clk);
    state_chk("R1", 0, 512);
    rst_n = 1'b1;
  endtask

  task automatic div_spacing(input int exp);
    int n = 0;
    do @(negedge clk); while (!div_pulse);
    do begin
      @(negedge clk);
      n++;
    end while (!div_pulse);
    chk("R8", "divider spacing", n, exp);
  endtask

  initial begin
    do_reset();
    for (int i = 0; i < NROW; i++) begin
      edge_then(GAP[i]);
      state_chk(TAG[i], EXP_M[i], EXP_W[i]);
    end
    div_spacing(1000);

    do_reset();
    edge_then(1900);
    repeat (26) edge_then(1900);
    state_chk("R9", 0, 0);
    edge_then(500);
    state_chk("R9", 0, 0);
    repeat (51) edge_then(500);
    state_chk("R9", 0, 1020);
    edge_then(500);
    state_chk("R9", 0, 1023);
    edge_then(500);
    state_chk("R9", 0, 1023);

    @(negedge clk) div_n = 12'd750;
    div_spacing(750);
    div_spacing(750);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule